// File: doc/BRIEF.md
# Infrared receive register and sample buffer interface

This block is the bus-facing side of an infrared receive peripheral. A sampler that sits after it turns the line into 8-bit run-length samples and pushes them into a buffer here. Software reaches the block through a simple register bus. It uses that bus to set up the receiver, to drain the buffered samples and to service the interrupt flags. The control fields the sampler needs are driven straight from the registers: global and receive enable, a two-bit mode field, input polarity inversion and a 16-bit sampling configuration word.

The buffer is a first-in first-out store whose depth is a power-of-two parameter. Depths of 16 and 64 are both supported. Three sticky flags sit in a status word: overflow, end of packet and data available. Each flag is cleared by writing a one to it. The current fill count can be read from the upper part of the same word. The interrupt line is the OR of every flag whose enable bit is set.

The bus has one cycle of read latency. A read request presented on one rising edge has its data on `rdata` after that edge.

Top module: `ir_rx_regs`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and all configuration outputs are 0.
- R2: The control word at 0x00 holds global enable (bit 0), receive enable (bit 1) and mode (bits 5:4). The receive configuration word at 0x10 holds polarity invert (bit 2). The sampling configuration word at 0x34 holds bits 15:0. Each of these reads back what was written and drives its output.
- R3: A read of 0x20 returns the oldest buffered sample in bits 7:0, removes it, and reduces the fill count by one.
- R4: In the status word at 0x30, bits 8 and up report the fill count in a field of log2(depth)+1 bits.
- R5: A push arriving while the buffer holds depth entries is discarded and sets the overflow flag (status bit 0). The buffered contents stay unchanged.
- R6: The data-available flag (status bit 4) is set whenever the fill count is greater than the trigger level. The trigger level sits in the enable word at 0x2C, bits 8 and up, log2(depth) bits wide.
- R7: Writing 1 to a status flag bit clears that flag, and writing 0 leaves it unchanged. If a flag's set condition holds in the same cycle as the clear, the set wins.
- R8: A pulse on `pkt_end` while both enables are set raises the end-of-packet flag (status bit 1).
- R9: `irq` is 1 one cycle after any flag is set while its enable bit in the enable word is set (bit 0 overflow, bit 1 end of packet, bit 4 data available). Otherwise it is 0.
- R10: While global enable is 0, the buffer is held empty. Pushes are discarded without raising overflow whenever global enable or receive enable is 0.
- R11: A read of 0x20 while the buffer is empty returns 0x00 and leaves the fill count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after the read strobe |
| push_valid | input | 1 | Sample push from the sampler |
| push_data | input | 8 | Sample value |
| pkt_end | input | 1 | End-of-packet pulse from the sampler |
| irq | output | 1 | Interrupt request |
| cfg_global_en | output | 1 | Global enable |
| cfg_rx_en | output | 1 | Receive enable |
| cfg_mode | output | 2 | Mode field |
| cfg_invert | output | 1 | Input polarity invert |
| cfg_sample | output | 16 | Sampling configuration word |

## Verification
Directed runs set the fill count to zero, to just under and just over the trigger level, and to exactly full plus one. This separates the off-by-one cases of the data-available comparison from the full test used for overflow. Flags are cleared both while their cause still holds and after it has gone, which shows whether set wins over clear. Random bursts of pushes and reads are checked against a queue model of the buffer, so ordering, pointer wrap and fill count are all compared. Pushes made with either enable low show whether the gating holds.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int SMP_W  = 8;
  localparam int SCFG_W = 16;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_RXCFG = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_FIFO  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_SCFG  = 8'h34;

  // bit positions shared by the enable and status words
  localparam int B_OVF   = 0;
  localparam int B_PEND  = 1;
  localparam int B_AVAIL = 4;
  localparam int B_FIELD = 8;
  // control and receive configuration bits
  localparam int B_GEN   = 0;
  localparam int B_REN   = 1;
  localparam int B_MODE  = 4;
  localparam int B_INV   = 2;

  localparam int NFLAG = 3;  // index 0 overflow, 1 packet end, 2 data available
endpackage

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo
  import ir_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [SMP_W-1:0] push_data,
  input  logic             pop,
  output logic [SMP_W-1:0] pop_data,
  output logic [CW-1:0]    count,
  output logic             drop
);
  logic [SMP_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             full, empty, wr_ok, rd_ok;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = push && !full && !flush;
  assign rd_ok = pop && !empty && !flush;
  assign drop  = push && full && !flush;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)      pop_data <= '0;
    else if (pop) pop_data <= rd_ok ? mem[rptr] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ir_rx_status.sv
module ir_rx_status
  import ir_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set,
  input  logic [NFLAG-1:0] clr,
  input  logic [NFLAG-1:0] en,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & en);
  end
endmodule

// File: rtl/ir_rx_regs.sv
module ir_rx_regs
  import ir_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              push_valid,
  input  logic [SMP_W-1:0]  push_data,
  input  logic              pkt_end,
  output logic              irq,
  output logic              cfg_global_en,
  output logic              cfg_rx_en,
  output logic [1:0]        cfg_mode,
  output logic              cfg_invert,
  output logic [SCFG_W-1:0] cfg_sample
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [NFLAG-1:0]  ien, flags, flag_set, flag_clr;
  logic [AW-1:0]     trig_lvl;
  logic [CW-1:0]     fill_cnt;
  logic [SMP_W-1:0]  fifo_q;
  logic              fifo_drop, fifo_pop, rx_active, sel_fifo_q;
  logic [DATA_W-1:0] reg_q, stat_word, ien_word, ctrl_word, rd_mux;

  logic wr_ctrl, wr_rxcfg, wr_ien, wr_stat, wr_scfg;
  assign wr_ctrl  = wr_en && addr == OFS_CTRL;
  assign wr_rxcfg = wr_en && addr == OFS_RXCFG;
  assign wr_ien   = wr_en && addr == OFS_IEN;
  assign wr_stat  = wr_en && addr == OFS_STAT;
  assign wr_scfg  = wr_en && addr == OFS_SCFG;
  assign fifo_pop = rd_en && addr == OFS_FIFO;
  assign rx_active = cfg_global_en && cfg_rx_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_global_en <= 1'b0;
      cfg_rx_en     <= 1'b0;
      cfg_mode      <= 2'b00;
      cfg_invert    <= 1'b0;
      cfg_sample    <= '0;
      ien           <= '0;
      trig_lvl      <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg_global_en <= wdata[B_GEN];
        cfg_rx_en     <= wdata[B_REN];
        cfg_mode      <= wdata[B_MODE +: 2];
      end
      if (wr_rxcfg) cfg_invert <= wdata[B_INV];
      if (wr_scfg)  cfg_sample <= wdata[SCFG_W-1:0];
      if (wr_ien) begin
        ien      <= {wdata[B_AVAIL], wdata[B_PEND], wdata[B_OVF]};
        trig_lvl <= wdata[B_FIELD +: AW];
      end
    end
  end

  ir_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (!cfg_global_en),
    .push      (push_valid && rx_active),
    .push_data (push_data),
    .pop       (fifo_pop),
    .pop_data  (fifo_q),
    .count     (fill_cnt),
    .drop      (fifo_drop)
  );

  assign flag_set = {fill_cnt > {1'b0, trig_lvl}, pkt_end && rx_active, fifo_drop};
  assign flag_clr = wr_stat ? {wdata[B_AVAIL], wdata[B_PEND], wdata[B_OVF]} : '0;

  ir_rx_status u_stat (
    .clk   (clk),
    .rst   (rst),
    .set   (flag_set),
    .clr   (flag_clr),
    .en    (ien),
    .flags (flags),
    .irq   (irq)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[B_GEN]      = cfg_global_en;
    ctrl_word[B_REN]      = cfg_rx_en;
    ctrl_word[B_MODE +: 2] = cfg_mode;
    ien_word = '0;
    ien_word[B_OVF]   = ien[0];
    ien_word[B_PEND]  = ien[1];
    ien_word[B_AVAIL] = ien[2];
    ien_word[B_FIELD +: AW] = trig_lvl;
    stat_word = '0;
    stat_word[B_OVF]   = flags[0];
    stat_word[B_PEND]  = flags[1];
    stat_word[B_AVAIL] = flags[2];
    stat_word[B_FIELD +: CW] = fill_cnt;
    case (addr)
      OFS_CTRL:  rd_mux = ctrl_word;
      OFS_RXCFG: rd_mux = DATA_W'({cfg_invert, 2'b00});
      OFS_IEN:   rd_mux = ien_word;
      OFS_STAT:  rd_mux = stat_word;
      OFS_SCFG:  rd_mux = DATA_W'(cfg_sample);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q      <= '0;
      sel_fifo_q <= 1'b0;
    end else if (rd_en) begin
      reg_q      <= rd_mux;
      sel_fifo_q <= fifo_pop;
    end
  end

  assign rdata = sel_fifo_q ? DATA_W'(fifo_q) : reg_q;
endmodule

// File: rtl/ir_rx_checker.sv
module ir_rx_checker #(
  parameter int DEPTH = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          gen,
  input logic          ren,
  input logic          push_valid,
  input logic          pop,
  input logic [CW-1:0] count,
  input logic [2:0]    flags,
  input logic [2:0]    ien,
  input logic          irq
);
  a_r5_count_cap: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  a_r5_ovf_set: assert property (@(posedge clk) disable iff (rst)
    (gen && ren && push_valid && count == CW'(DEPTH)) |=> flags[0]);

  a_r10_flush: assert property (@(posedge clk) disable iff (rst)
    !gen |=> count == '0);

  a_r3_pop_dec: assert property (@(posedge clk) disable iff (rst)
    (gen && pop && count != '0 && !(ren && push_valid)) |=> count == $past(count) - 1'b1);

  a_r11_empty_hold: assert property (@(posedge clk) disable iff (rst)
    (pop && count == '0 && !(gen && ren && push_valid)) |=> count == '0);

  a_r9_irq_on: assert property (@(posedge clk) disable iff (rst)
    (|(flags & ien)) |=> irq);

  a_r9_irq_off: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & ien)) |=> !irq);
endmodule

bind ir_rx_regs ir_rx_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .gen        (cfg_global_en),
  .ren        (cfg_rx_en),
  .push_valid (push_valid),
  .pop        (fifo_pop),
  .count      (fill_cnt),
  .flags      (flags),
  .ien        (ien),
  .irq        (irq)
);

// File: tb/sim_ir_rx_regs.sv
`timescale 1ns/1ps
module sim_ir_rx_regs;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0, push_valid = 0, pkt_end = 0;
  logic [7:0] addr = 0, push_data = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq, g_en, r_en, inv;
  logic [1:0] mode;
  logic [15:0] scfg;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [$];

  always #2 clk = ~clk;

  ir_rx_regs #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .push_valid(push_valid), .push_data(push_data),
    .pkt_end(pkt_end), .irq(irq), .cfg_global_en(g_en), .cfg_rx_en(r_en),
    .cfg_mode(mode), .cfg_invert(inv), .cfg_sample(scfg)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] cnt_of(input logic [31:0] st);
    return (st >> 8) & ((1 << CW) - 1);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(posedge clk); #1 d = rdata; rd_en = 0;
  endtask

  task automatic push(input logic [7:0] v, input bit accepted);
    @(negedge clk); push_valid = 1; push_data = v;
    @(posedge clk); #1 push_valid = 0;
    if (accepted && model.size() < DEPTH) model.push_back(v);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain(input string req);
    logic [31:0] d;
    while (model.size() > 0) begin
      rd(8'h20, d);
      chk(req, d, {24'h0, model.pop_front()});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] v;
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 outputs", {g_en, r_en, mode, inv, scfg}, 0);
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h30, d); chk("R1 status", d, 0);
    rd(8'h2C, d); chk("R1 enable", d, 0);

    // R2 configuration words
    wr(8'h00, 32'h33); wr(8'h10, 32'h4); wr(8'h34, 32'hABCD);
    rd(8'h00, d); chk("R2 ctrl readback", d, 32'h33);
    rd(8'h10, d); chk("R2 rxcfg readback", d, 32'h4);
    rd(8'h34, d); chk("R2 sample readback", d, 32'hABCD);
    chk("R2 outputs", {g_en, r_en, mode, inv, scfg}, {1'b1, 1'b1, 2'b11, 1'b1, 16'hABCD});

    // R3 R4 random bursts
    for (int b = 0; b < 4; b++) begin
      int n = $urandom_range(3, 12);
      for (int i = 0; i < n; i++) push(8'($urandom), 1);
      rd(8'h30, d); chk("R4 fill count", cnt_of(d), n);
      rd(8'h20, d); chk("R3 oldest first", d, {24'h0, model.pop_front()});
      rd(8'h30, d); chk("R3 count after pop", cnt_of(d), n - 1);
      drain("R3 order");
    end

    // R11 empty read
    rd(8'h20, d); chk("R11 empty data", d, 0);
    rd(8'h30, d); chk("R11 empty count", cnt_of(d), 0);

    // R5 overflow
    wr(8'h30, 32'h13);
    for (int i = 0; i < DEPTH; i++) push(8'(i * 7 + 3), 1);
    rd(8'h30, d); chk("R5 no ovf at full", d & 1, 0);
    chk("R4 full count", cnt_of(d), DEPTH);
    push(8'hEE, 0);
    rd(8'h30, d); chk("R5 ovf flag", d & 1, 1);
    chk("R5 count held", cnt_of(d), DEPTH);
    drain("R5 contents kept");

    // R7 write one to clear
    wr(8'h30, 32'h0);
    rd(8'h30, d); chk("R7 zero write keeps", d & 1, 1);
    wr(8'h30, 32'h1);
    rd(8'h30, d); chk("R7 one write clears", d & 1, 0);

    // R6 trigger level 5
    wr(8'h2C, 32'h500); wr(8'h30, 32'h13);
    for (int i = 0; i < 5; i++) push(8'($urandom), 1);
    idle(2);
    rd(8'h30, d); chk("R6 at level", (d >> 4) & 1, 0);
    push(8'h5A, 1); idle(2);
    rd(8'h30, d); chk("R6 above level", (d >> 4) & 1, 1);
    wr(8'h30, 32'h10); idle(1);
    rd(8'h30, d); chk("R7 set wins while above", (d >> 4) & 1, 1);
    rd(8'h20, d); void'(model.pop_front());
    rd(8'h30, d); chk("R6 sticky", (d >> 4) & 1, 1);
    wr(8'h30, 32'h10); idle(1);
    rd(8'h30, d); chk("R7 cleared below", (d >> 4) & 1, 0);
    drain("R3 drain");

    // R8 packet end
    wr(8'h30, 32'h13);
    @(negedge clk); pkt_end = 1; @(posedge clk); #1 pkt_end = 0;
    rd(8'h30, d); chk("R8 packet end flag", (d >> 1) & 1, 1);

    // R9 interrupt
    idle(3); chk("R9 masked", irq, 0);
    wr(8'h2C, 32'h502); idle(3); chk("R9 enabled", irq, 1);
    wr(8'h30, 32'h2); idle(3); chk("R9 cleared", irq, 0);
    wr(8'h2C, 32'h511);
    for (int i = 0; i < 6; i++) push(8'($urandom), 1);
    idle(3); chk("R9 avail irq", irq, 1);

    // R10 flush and gating
    wr(8'h00, 32'h32); model.delete(); idle(1);
    rd(8'h30, d); chk("R10 flushed", cnt_of(d), 0);
    push(8'h11, 0); rd(8'h30, d);
    chk("R10 push ignored, global off", cnt_of(d), 0);
    wr(8'h30, 32'h13);
    wr(8'h00, 32'h31);
    push(8'h22, 0); rd(8'h30, d);
    chk("R10 push ignored, rx off", d & 32'h1ff13, 0);

    // random mix
    wr(8'h00, 32'h33); wr(8'h2C, 32'hF00);
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 2) != 0) push(8'($urandom), 1);
      else begin
        rd(8'h20, d);
        if (model.size() > 0) chk("R3 random order", d, {24'h0, model.pop_front()});
        else chk("R11 random empty", d, 0);
      end
      if (i % 25 == 0) begin
        rd(8'h30, d); chk("R4 random count", cnt_of(d), model.size());
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule